// File: doc/BRIEF.md
# Stream packet abort tracker

This block watches a ready/valid request stream whose beats carry an abort sideband bit. When the source raises the abort bit on an accepted beat of a packet that carries a payload, the block marks that packet as aborted. From then on it treats every remaining beat of the packet as part of an aborted packet, even if the source lowers the abort bit. On the accepted last beat of an aborted packet it produces a nullify flag and an error-report pulse. A downstream stage uses these to drop the packet and to report an uncorrectable internal error.

The block also checks how the source drives the abort bit. It flags three protocol violations: the abort bit raised with valid low, the abort bit withdrawn before a beat with ready high has accepted it, and a second packet starting in the same beat that ends an aborted packet. Each violation flag stays set until the clear input is pulsed. Every output is registered.

Top module: `pkt_abort_tracker`

## Requirements
- R1: After a synchronous reset, `nullify`, `err_pulse`, `pkt_aborted` and all three bits of `viol_flags` are low.
- R2: The abort bit is sampled only on beats where `s_valid` and `s_ready` are both high. While `s_ready` is low, a raised abort bit leaves `pkt_aborted` low.
- R3: After an accepted abort beat that is not the last beat, `pkt_aborted` is high from the next cycle. It stays high through the later beats of the packet, even when `s_disc` is low on those beats.
- R4: When the abort beat is also the last beat, `nullify` is high in the cycle after that beat and `pkt_aborted` stays low.
- R5: `nullify` and `err_pulse` are high together for exactly one cycle, in the cycle after the accepted last beat of an aborted packet. `pkt_aborted` is low in that cycle.
- R6: The abort bit on a packet without payload has no effect: `pkt_aborted` and `nullify` stay low.
- R7: `s_has_pld` is taken on the first accepted beat of a packet. Its value on later beats of the same packet is ignored.
- R8: `viol_flags[0]` sets in the cycle after a cycle with `s_disc` high and `s_valid` low.
- R9: `viol_flags[1]` sets in the cycle after a cycle in which `s_disc` is low, when the previous cycle had `s_valid` and `s_disc` high with `s_ready` low.
- R10: `viol_flags[2]` sets in the cycle after an accepted last beat that carries a sampled abort on a payload packet while `s_sop2` (a second packet starting in the same beat) is high.
- R11: Each `viol_flags` bit stays set until `viol_clr` is high. A cycle with `viol_clr` high leaves all bits low in the next cycle, and the clear takes priority over new violations.
- R12: A packet without a sampled abort never produces `nullify` or `err_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Beat valid from the source |
| s_ready | input | 1 | Beat ready from the sink |
| s_last | input | 1 | Last beat of the packet |
| s_disc | input | 1 | Abort sideband bit |
| s_has_pld | input | 1 | Packet carries a payload (taken on the first beat) |
| s_sop2 | input | 1 | A second packet starts within this beat |
| viol_clr | input | 1 | Synchronous clear of the violation flags |
| nullify | output | 1 | One-cycle flag: the packet that just ended must be dropped |
| err_pulse | output | 1 | One-cycle uncorrectable-error report |
| pkt_aborted | output | 1 | The packet in progress has been aborted |
| viol_flags | output | 3 | Sticky violations: bit0 abort with valid low, bit1 abort withdrawn early, bit2 new packet in the abort beat |

## Verification
The hardest situation to reach is an abort that persists across a stalled beat and is then withdrawn, all in the middle of a payload packet whose payload indication changes after its first beat. The stimulus builds this case from explicit beat sequences: a stall with ready low while the abort bit is held, an accepted abort that is not the last beat, and later beats with the abort bit low and the payload indication flipped. A behavioural model in the bench predicts every output, and the bench compares against it on every cycle.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int VIOL_W   = 3;
  localparam int V_IDLE   = 0; // abort with valid low
  localparam int V_DROP   = 1; // abort withdrawn before acceptance
  localparam int V_SOP    = 2; // new packet in abort-ending beat
endpackage

// File: rtl/pa_beat_track.sv
module pa_beat_track (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic last,
  input  logic disc,
  input  logic has_pld,
  output logic abort_now,
  output logic aborted_q,
  output logic nullify_q,
  output logic err_q
);
  logic in_pkt_q;
  logic pld_q;
  logic pld_eff;
  logic end_aborted;

  // payload indication is latched on the first beat of each packet
  assign pld_eff     = in_pkt_q ? pld_q : has_pld;
  assign abort_now   = acc && disc && pld_eff;
  assign end_aborted = acc && last && (aborted_q || abort_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt_q  <= 1'b0;
      pld_q     <= 1'b0;
      aborted_q <= 1'b0;
      nullify_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      nullify_q <= end_aborted;
      err_q     <= end_aborted;
      if (acc) begin
        in_pkt_q <= !last;
        if (!in_pkt_q) pld_q <= has_pld;
        if (last)           aborted_q <= 1'b0;
        else if (abort_now) aborted_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pa_rule_check.sv
module pa_rule_check
  import pa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              ready,
  input  logic              disc,
  input  logic              acc,
  input  logic              last,
  input  logic              abort_now,
  input  logic              sop2,
  input  logic              clr,
  output logic [VIOL_W-1:0] viol_q
);
  logic              hold_q;
  logic [VIOL_W-1:0] evt;

  always_comb begin
    evt         = '0;
    evt[V_IDLE] = disc && !valid;
    evt[V_DROP] = hold_q && !disc;
    evt[V_SOP]  = acc && last && abort_now && sop2;
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= valid && disc && !ready;
  end

  for (genvar i = 0; i < VIOL_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr)  viol_q[i] <= 1'b0;
      else if (evt[i]) viol_q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/pkt_abort_tracker.sv
module pkt_abort_tracker
  import pa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic              s_ready,
  input  logic              s_last,
  input  logic              s_disc,
  input  logic              s_has_pld,
  input  logic              s_sop2,
  input  logic              viol_clr,
  output logic              nullify,
  output logic              err_pulse,
  output logic              pkt_aborted,
  output logic [VIOL_W-1:0] viol_flags
);
  logic acc;
  logic abort_now;

  assign acc = s_valid && s_ready;

  pa_beat_track u_track (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc),
    .last      (s_last),
    .disc      (s_disc),
    .has_pld   (s_has_pld),
    .abort_now (abort_now),
    .aborted_q (pkt_aborted),
    .nullify_q (nullify),
    .err_q     (err_pulse)
  );

  pa_rule_check u_rules (
    .clk       (clk),
    .rst       (rst),
    .valid     (s_valid),
    .ready     (s_ready),
    .disc      (s_disc),
    .acc       (acc),
    .last      (s_last),
    .abort_now (abort_now),
    .sop2      (s_sop2),
    .clr       (viol_clr),
    .viol_q    (viol_flags)
  );
endmodule

// File: rtl/pa_checker.sv
module pa_checker
  import pa_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              s_valid,
  input logic              s_ready,
  input logic              s_last,
  input logic              s_disc,
  input logic              viol_clr,
  input logic              nullify,
  input logic              err_pulse,
  input logic              pkt_aborted,
  input logic [VIOL_W-1:0] viol_flags
);
  a_r5_pulse_pair: assert property (@(posedge clk) disable iff (rst)
    nullify == err_pulse);
  a_r5_after_last: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && s_last) |=> !pkt_aborted);
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (nullify && !(s_valid && s_ready && s_last)) |=> !nullify);
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (pkt_aborted && !(s_valid && s_ready && s_last)) |=> pkt_aborted);
  a_r2_no_sample_stall: assert property (@(posedge clk) disable iff (rst)
    (!pkt_aborted && !(s_valid && s_ready)) |=> !pkt_aborted);
  a_r8_idle_disc: assert property (@(posedge clk) disable iff (rst)
    (s_disc && !s_valid && !viol_clr) |=> viol_flags[V_IDLE]);
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (viol_flags[V_DROP] && !viol_clr) |=> viol_flags[V_DROP]);
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    viol_clr |=> (viol_flags == '0));
endmodule

bind pkt_abort_tracker pa_checker u_pa_checker (
  .clk         (clk),
  .rst         (rst),
  .s_valid     (s_valid),
  .s_ready     (s_ready),
  .s_last      (s_last),
  .s_disc      (s_disc),
  .viol_clr    (viol_clr),
  .nullify     (nullify),
  .err_pulse   (err_pulse),
  .pkt_aborted (pkt_aborted),
  .viol_flags  (viol_flags)
);

// File: tb/tb_pkt_abort_tracker.sv
module tb_pkt_abort_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 0, s_ready = 0, s_last = 0, s_disc = 0;
  logic s_has_pld = 0, s_sop2 = 0, viol_clr = 0;
  logic nullify, err_pulse, pkt_aborted;
  logic [2:0] viol_flags;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_in_pkt, m_pld, m_ab, m_nul, m_hold;
  bit [2:0] m_viol;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_abort_tracker dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_last(s_last), .s_disc(s_disc), .s_has_pld(s_has_pld),
    .s_sop2(s_sop2), .viol_clr(viol_clr), .nullify(nullify),
    .err_pulse(err_pulse), .pkt_aborted(pkt_aborted),
    .viol_flags(viol_flags)
  );

  always @(posedge clk) begin
    bit acc, pe, dn;
    bit [2:0] ev;
    cycles++;
    if (rst) begin
      m_in_pkt = 0; m_pld = 0; m_ab = 0; m_nul = 0; m_hold = 0; m_viol = 0;
    end else begin
      acc = s_valid && s_ready;
      pe  = m_in_pkt ? m_pld : s_has_pld;
      dn  = acc && s_disc && pe;
      ev  = '0;
      ev[0] = s_disc && !s_valid;
      ev[1] = m_hold && !s_disc;
      ev[2] = acc && s_last && dn && s_sop2;
      if (viol_clr) m_viol = 0; else m_viol = m_viol | ev;
      m_nul  = acc && s_last && (m_ab || dn);
      m_hold = s_valid && s_disc && !s_ready;
      if (acc) begin
        if (!m_in_pkt) m_pld = s_has_pld;
        if (s_last) m_ab = 0; else if (dn) m_ab = 1;
        m_in_pkt = !s_last;
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("nullify", nullify, m_nul);
    chk("err_pulse", err_pulse, m_nul);
    chk("pkt_aborted", pkt_aborted, m_ab);
    chk("viol_flags", viol_flags, m_viol);
  endtask

  // drive one cycle of inputs, then compare at the following negedge
  task automatic step(bit v, bit r, bit l, bit d, bit hp, bit s2, bit c);
    s_valid = v; s_ready = r; s_last = l; s_disc = d;
    s_has_pld = hp; s_sop2 = s2; viol_clr = c;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic clear();
    step(0, 1, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk("reset nullify", nullify, 0);
    chk("reset aborted", pkt_aborted, 0);
    chk("reset viol", viol_flags, 0);

    // R12 clean packet
    cur_req = "R12";
    step(1, 1, 0, 0, 1, 0, 0); step(1, 1, 0, 0, 0, 0, 0); step(1, 1, 1, 0, 0, 0, 0);
    chk("R12 no nullify", nullify, 0);
    idle(1);

    // R2 stall with abort held, then accepted (R3 sticky afterwards)
    cur_req = "R2";
    step(1, 1, 0, 0, 1, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0);
    chk("R2 not sampled while stalled", pkt_aborted, 0);
    step(1, 0, 0, 1, 0, 0, 0);
    cur_req = "R3";
    step(1, 1, 0, 1, 0, 0, 0);
    chk("R3 aborted set", pkt_aborted, 1);
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R3 still aborted", pkt_aborted, 1);
    cur_req = "R5";
    step(1, 1, 1, 0, 0, 0, 0);
    chk("R5 nullify", nullify, 1);
    chk("R5 err", err_pulse, 1);
    chk("R5 aborted cleared", pkt_aborted, 0);
    idle(1);
    chk("R5 one cycle", nullify, 0);

    // R4 early end in abort beat
    cur_req = "R4";
    step(1, 1, 0, 0, 1, 0, 0);
    step(1, 1, 1, 1, 1, 0, 0);
    chk("R4 nullify", nullify, 1);
    chk("R4 aborted low", pkt_aborted, 0);
    idle(2);

    // R6 no payload packet ignores abort
    cur_req = "R6";
    step(1, 1, 0, 1, 0, 0, 0);
    chk("R6 aborted low", pkt_aborted, 0);
    step(1, 1, 1, 1, 0, 0, 0);
    chk("R6 no nullify", nullify, 0);
    idle(1);

    // R7 payload flag changes mid-packet are ignored
    cur_req = "R7";
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 1, 1, 0, 0);
    chk("R7 aborted low", pkt_aborted, 0);
    step(1, 1, 1, 0, 1, 0, 0);
    chk("R7 no nullify", nullify, 0);
    step(1, 1, 0, 0, 1, 0, 0);
    step(1, 1, 0, 1, 0, 0, 0);
    chk("R7 latched payload", pkt_aborted, 1);
    step(1, 1, 1, 0, 0, 0, 0);
    chk("R7 nullify", nullify, 1);
    idle(1);

    // R8 abort with valid low
    cur_req = "R8";
    step(0, 1, 0, 1, 0, 0, 0);
    chk("R8 idle flag", viol_flags[0], 1);
    idle(2);
    cur_req = "R11";
    chk("R11 held", viol_flags[0], 1);
    clear();
    chk("R11 cleared", viol_flags, 0);

    // R9 abort dropped before acceptance
    cur_req = "R9";
    step(1, 1, 0, 0, 1, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R9 drop flag", viol_flags[1], 1);
    step(1, 1, 1, 0, 0, 0, 0);
    chk("R9 no nullify", nullify, 0);
    idle(1);

    // R11 clear wins over a simultaneous event
    cur_req = "R11";
    step(0, 1, 0, 1, 0, 0, 1);
    chk("R11 clear priority", viol_flags, 0);
    idle(1);

    // R10 new packet in abort-ending beat
    cur_req = "R10";
    step(1, 1, 0, 0, 1, 0, 0);
    step(1, 1, 1, 1, 0, 1, 0);
    chk("R10 sop flag", viol_flags[2], 1);
    chk("R10 nullify", nullify, 1);
    step(1, 1, 1, 0, 0, 0, 0);
    clear();
    // sop2 on a clean end is allowed
    step(1, 1, 0, 0, 1, 0, 0);
    step(1, 1, 1, 0, 0, 1, 0);
    chk("R10 clean sop ok", viol_flags, 0);
    idle(2);

    // R1 reset mid-abort
    cur_req = "R1";
    step(1, 1, 0, 1, 1, 0, 0);
    step(0, 1, 0, 1, 0, 0, 0);
    rst = 1;
    step(0, 1, 0, 0, 0, 0, 0);
    rst = 0;
    chk("R1 reset aborted", pkt_aborted, 0);
    chk("R1 reset viol", viol_flags, 0);
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > WATCHDOG);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule